// File: doc/BRIEF.md
# Multiprocessor Nine-Bit UART

This block is a full-duplex asynchronous serial port. It sits behind a byte-wide register port with two addresses: a control/status byte and a data byte. Writing the data byte sends a frame on `txd`. A frame arriving on `rxd` is placed in the receive buffer, which is read back through the same data address. Each direction raises an interrupt flag that stays set until software clears it. A flag is cleared by writing a byte that holds a 0 in that flag's position and 1 in every other flag position. Writing a 1 to a flag never changes it, so a clear of one flag cannot lose a flag that hardware sets at the same moment.

A two-bit mode field selects one of three frame formats. The first is 8 data bits at a variable rate. The second is 9 data bits at a fixed rate, derived from the system clock. The third is 9 data bits at a variable rate. The variable rates come from an external 16x oversampling tick. In a multidrop bus, the ninth bit marks address frames. When the multiprocessor enable is set, the receiver only interrupts on frames whose ninth bit is 1. Frames whose ninth bit is 0 are dropped, so a slave stays quiet until it is addressed.

Top module: `mpUart`

## Requirements
- R1: After reset, the control byte reads 0x00, `txd` is high and both interrupt outputs are low.
- R2: Control bits [7:6] select the mode. 01 is an 8-bit frame on the `baudTick` rate. 11 is a 9-bit frame on the `baudTick` rate. 10 is a 9-bit frame on a tick made every FIX_DIV system clocks. 00 disables the port: a data write sends nothing and no frame is received.
- R3: A transmitted frame has these bits, each lasting 16 ticks: a start bit of 0, then data LSB first, then (in the 9-bit modes only) control bit 3 as the ninth bit, then a stop bit of 1.
- R4: Control bit 1 (`txIrq`) is set when the stop bit of a sent frame has ended. A data write (address 1) made while a frame is being sent is ignored.
- R5: Reception requires control bit 4 to be 1. While it is 0, a frame on `rxd` neither sets the receive flag nor changes the buffer.
- R6: When a frame is received, its data byte is read back at address 1, and control bit 0 (`rxIrq`) is set. Control bit 2 holds the received ninth bit in the 9-bit modes, and the received stop bit in the 8-bit mode.
- R7: With control bit 5 set in a 9-bit mode, a frame whose ninth bit is 0 is neither loaded nor flagged. A frame whose ninth bit is 1 is loaded and flagged.
- R8: A frame whose stop bit is 0 is loaded into the buffer, and control bit 2 takes that stop bit. The receive flag is not set.
- R9: A control write clears each flag (bits 1 and 0) where it holds a 0, and leaves the flag unchanged where it holds a 1. A hardware set in the same cycle wins over the clear. Bit 2 ignores writes.
- R10: A low pulse on `rxd` that has ended by the middle of the start bit does not start reception. A real frame that follows it is received correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| wrEn | input | 1 | Register write strobe |
| regAddr | input | 1 | 0 = control/status byte, 1 = data byte |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data for `regAddr` (combinational) |
| baudTick | input | 1 | 16x oversampling tick for the variable-rate modes |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line, idle high |
| txIrq | output | 1 | Transmit-done flag |
| rxIrq | output | 1 | Receive flag |

## Verification
The bench first clears the receive flag with a control write that holds 1 in the transmit-flag position. A design that let written ones through would set that flag. The bench writes a second byte while a frame is still going out; a design that accepted it would send an extra frame, which the scoreboard reports as unexpected. It sends address and data frames with the multiprocessor filter on, and a frame with a bad stop bit. A design that leaked the filter, or flagged the bad frame, would raise `rxIrq`. It also puts a short glitch on `rxd` ahead of a real frame. A receiver that skipped the mid-start recheck would decode shifted garbage.

// File: rtl/mpUartPkg.sv
package mpUartPkg;

  typedef enum logic [1:0] {
    MODE_OFF = 2'b00,
    MODE_8V  = 2'b01,
    MODE_9F  = 2'b10,
    MODE_9V  = 2'b11
  } frameMode_t;

  typedef enum logic [1:0] {
    RX_IDLE  = 2'd0,
    RX_START = 2'd1,
    RX_BITS  = 2'd2
  } rxState_t;

  // control -> datapath
  typedef struct packed {
    logic       txStart;
    logic [7:0] txByte;
    logic       txNinth;
    frameMode_t mode;
    logic       rxEnable;
    logic       mpEnable;
  } ctlStrobe_t;

  // datapath -> control
  typedef struct packed {
    logic       txDone;
    logic       rxLoad;
    logic       rxFlag;
    logic [7:0] rxByte;
    logic       rxNinth;
  } dpEvent_t;

  // control byte field positions
  localparam int BIT_RXF  = 0;
  localparam int BIT_TXF  = 1;
  localparam int BIT_RX9  = 2;
  localparam int BIT_TX9  = 3;
  localparam int BIT_REN  = 4;
  localparam int BIT_MPE  = 5;
  localparam int BIT_MLO  = 6;
  localparam int BIT_MHI  = 7;

endpackage

// File: rtl/mpUartCtrl.sv
module mpUartCtrl
  import mpUartPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrEn,
  input  logic       regAddr,
  input  logic [7:0] wrData,
  output logic [7:0] rdData,
  input  dpEvent_t   dpEv,
  input  logic       txBusy,
  output ctlStrobe_t ctlStb,
  output logic       txIrq,
  output logic       rxIrq
);

  frameMode_t modeR;
  logic       mpEnR;
  logic       rxEnR;
  logic       txNinthR;
  logic       rxNinthR;
  logic       txFlagR;
  logic       rxFlagR;
  logic [7:0] rxBufR;

  logic ctrlWr;
  logic dataWr;

  assign ctrlWr = wrEn && (regAddr == 1'b0);
  assign dataWr = wrEn && (regAddr == 1'b1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeR    <= MODE_OFF;
      mpEnR    <= 1'b0;
      rxEnR    <= 1'b0;
      txNinthR <= 1'b0;
      rxNinthR <= 1'b0;
      txFlagR  <= 1'b0;
      rxFlagR  <= 1'b0;
      rxBufR   <= '0;
    end else begin
      if (ctrlWr) begin
        modeR    <= frameMode_t'(wrData[BIT_MHI:BIT_MLO]);
        mpEnR    <= wrData[BIT_MPE];
        rxEnR    <= wrData[BIT_REN];
        txNinthR <= wrData[BIT_TX9];
      end
      // hardware set wins; software can only clear with a written 0
      if (dpEv.txDone)                       txFlagR <= 1'b1;
      else if (ctrlWr && !wrData[BIT_TXF])   txFlagR <= 1'b0;
      if (dpEv.rxFlag)                       rxFlagR <= 1'b1;
      else if (ctrlWr && !wrData[BIT_RXF])   rxFlagR <= 1'b0;
      if (dpEv.rxLoad) begin
        rxBufR   <= dpEv.rxByte;
        rxNinthR <= dpEv.rxNinth;
      end
    end
  end

  always_comb begin
    ctlStb.txStart  = dataWr && !txBusy && (modeR != MODE_OFF);
    ctlStb.txByte   = wrData;
    ctlStb.txNinth  = txNinthR;
    ctlStb.mode     = modeR;
    ctlStb.rxEnable = rxEnR;
    ctlStb.mpEnable = mpEnR;
  end

  always_comb begin
    if (regAddr == 1'b0)
      rdData = {modeR, mpEnR, rxEnR, txNinthR, rxNinthR, txFlagR, rxFlagR};
    else
      rdData = rxBufR;
  end

  assign txIrq = txFlagR;
  assign rxIrq = rxFlagR;

endmodule

// File: rtl/mpUartDp.sv
module mpUartDp
  import mpUartPkg::*;
#(
  parameter int FIX_DIV = 4,
  parameter int OSR     = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  ctlStrobe_t ctlStb,
  input  logic       baudTick,
  input  logic       rxd,
  output logic       txd,
  output logic       txBusy,
  output dpEvent_t   dpEv
);

  localparam int DW = (FIX_DIV > 1) ? $clog2(FIX_DIV) : 1;
  localparam int TW = $clog2(OSR);
  localparam logic [DW-1:0] DIV_MAX  = DW'(FIX_DIV - 1);
  localparam logic [TW-1:0] TICK_MAX = TW'(OSR - 1);
  localparam logic [TW-1:0] TICK_MID = TW'(OSR / 2 - 1);

  // ---------------- tick selection ----------------
  logic [DW-1:0] divCnt;
  logic          fixTick;
  logic          tick;
  logic          nine;

  generate
    if (FIX_DIV > 1) begin : g_div
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)                divCnt <= '0;
        else if (divCnt == DIV_MAX) divCnt <= '0;
        else                      divCnt <= divCnt + 1'b1;
      end
      assign fixTick = (divCnt == DIV_MAX);
    end else begin : g_nodiv
      assign divCnt  = '0;
      assign fixTick = 1'b1;
    end
  endgenerate

  always_comb begin
    unique case (ctlStb.mode)
      MODE_9F:          tick = fixTick;
      MODE_8V, MODE_9V: tick = baudTick;
      default:          tick = 1'b0;
    endcase
  end

  assign nine = ctlStb.mode[1];

  // ---------------- transmitter ----------------
  logic [10:0]   txSh;
  logic [3:0]    txCnt;
  logic [3:0]    txLastR;
  logic [TW-1:0] txTick;
  logic          txBusyR;
  logic          txEnd;

  assign txEnd = txBusyR && tick && (txTick == TICK_MAX) && (txCnt == txLastR);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txSh    <= '1;
      txCnt   <= '0;
      txLastR <= '0;
      txTick  <= '0;
      txBusyR <= 1'b0;
    end else if (!txBusyR) begin
      if (ctlStb.txStart) begin
        txSh    <= {1'b1, (nine ? ctlStb.txNinth : 1'b1), ctlStb.txByte, 1'b0};
        txLastR <= nine ? 4'd10 : 4'd9;
        txCnt   <= '0;
        txTick  <= '0;
        txBusyR <= 1'b1;
      end
    end else if (tick) begin
      if (txTick == TICK_MAX) begin
        txTick <= '0;
        txSh   <= {1'b1, txSh[10:1]};
        if (txCnt == txLastR) txBusyR <= 1'b0;
        else                  txCnt   <= txCnt + 1'b1;
      end else begin
        txTick <= txTick + 1'b1;
      end
    end
  end

  assign txd    = txBusyR ? txSh[0] : 1'b1;
  assign txBusy = txBusyR;

  // ---------------- receiver ----------------
  logic          rxMeta;
  logic          rxS;
  rxState_t      rxState;
  logic [TW-1:0] rxTick;
  logic [3:0]    rxIdx;
  logic [3:0]    rxLast;
  logic [8:0]    rxShR;
  logic          rxOn;
  logic          rxFinal;
  logic          gateOk;

  assign rxOn   = ctlStb.rxEnable && (ctlStb.mode != MODE_OFF);
  assign rxLast = nine ? 4'd9 : 4'd8;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxMeta <= 1'b1;
      rxS    <= 1'b1;
    end else begin
      rxMeta <= rxd;
      rxS    <= rxMeta;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxState <= RX_IDLE;
      rxTick  <= '0;
      rxIdx   <= '0;
      rxShR   <= '0;
    end else if (!rxOn) begin
      rxState <= RX_IDLE;
    end else begin
      unique case (rxState)
        RX_IDLE: begin
          if (!rxS) begin
            rxState <= RX_START;
            rxTick  <= '0;
          end
        end
        RX_START: begin
          if (tick) begin
            if (rxTick == TICK_MID) begin
              if (rxS) rxState <= RX_IDLE;
              else begin
                rxState <= RX_BITS;
                rxTick  <= '0;
                rxIdx   <= '0;
              end
            end else begin
              rxTick <= rxTick + 1'b1;
            end
          end
        end
        RX_BITS: begin
          if (tick) begin
            if (rxTick == TICK_MAX) begin
              rxTick <= '0;
              if (rxIdx == rxLast) rxState <= RX_IDLE;
              else begin
                rxShR[rxIdx] <= rxS;
                rxIdx        <= rxIdx + 1'b1;
              end
            end else begin
              rxTick <= rxTick + 1'b1;
            end
          end
        end
        default: rxState <= RX_IDLE;
      endcase
    end
  end

  assign rxFinal = rxOn && (rxState == RX_BITS) && tick &&
                   (rxTick == TICK_MAX) && (rxIdx == rxLast);
  assign gateOk  = !(ctlStb.mpEnable && nine && !rxShR[8]);

  always_comb begin
    dpEv.txDone  = txEnd;
    dpEv.rxLoad  = rxFinal && gateOk;
    dpEv.rxFlag  = rxFinal && gateOk && rxS;
    dpEv.rxByte  = rxShR[7:0];
    dpEv.rxNinth = nine ? rxShR[8] : rxS;
  end

endmodule

// File: rtl/mpUart.sv
module mpUart
  import mpUartPkg::*;
#(
  parameter int FIX_DIV = 4,
  parameter int OSR     = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrEn,
  input  logic       regAddr,
  input  logic [7:0] wrData,
  output logic [7:0] rdData,
  input  logic       baudTick,
  input  logic       rxd,
  output logic       txd,
  output logic       txIrq,
  output logic       rxIrq
);

  ctlStrobe_t ctlStb;
  dpEvent_t   dpEv;
  logic       txBusy;

  mpUartCtrl uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .wrEn    (wrEn),
    .regAddr (regAddr),
    .wrData  (wrData),
    .rdData  (rdData),
    .dpEv    (dpEv),
    .txBusy  (txBusy),
    .ctlStb  (ctlStb),
    .txIrq   (txIrq),
    .rxIrq   (rxIrq)
  );

  mpUartDp #(.FIX_DIV(FIX_DIV), .OSR(OSR)) uDp (
    .clk      (clk),
    .rstN     (rstN),
    .ctlStb   (ctlStb),
    .baudTick (baudTick),
    .rxd      (rxd),
    .txd      (txd),
    .txBusy   (txBusy),
    .dpEv     (dpEv)
  );

endmodule

// File: rtl/mpUartChk.sv
module mpUartChk (
  input logic       clk,
  input logic       rstN,
  input logic       wrEn,
  input logic       regAddr,
  input logic [7:0] wrData,
  input logic       txd,
  input logic       txIrq,
  input logic       rxIrq,
  input logic       txBusy,
  input logic       rxSet,
  input logic [1:0] modeBits
);

  logic ctrlWr;
  assign ctrlWr = wrEn && !regAddr;

  // R2
  mode_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    (modeBits == 2'b00 && !txBusy) |=> !txBusy);

  // R3
  stop_level_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(txIrq) |-> txd);

  // R9
  rx_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlWr && !wrData[0] && !rxSet) |=> !rxIrq);

  // R9
  rx_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rxIrq && !(ctrlWr && !wrData[0])) |=> rxIrq);

  // R9
  rx_set_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    rxSet |=> rxIrq);

endmodule

bind mpUart mpUartChk uChk (
  .clk      (clk),
  .rstN     (rstN),
  .wrEn     (wrEn),
  .regAddr  (regAddr),
  .wrData   (wrData),
  .txd      (txd),
  .txIrq    (txIrq),
  .rxIrq    (rxIrq),
  .txBusy   (txBusy),
  .rxSet    (dpEv.rxFlag),
  .modeBits (ctlStb.mode)
);

// File: tb/tb_mpUart.sv
module tb_mpUart;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic       regAddr = 1'b0;
  logic [7:0] wrData = '0;
  logic [7:0] rdData;
  logic       baudTick = 1'b0;
  logic       rxd = 1'b1;
  logic       txd;
  logic       txIrq;
  logic       rxIrq;

  always #2 clk = ~clk;

  mpUart #(.FIX_DIV(4)) dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .regAddr(regAddr), .wrData(wrData),
    .rdData(rdData), .baudTick(baudTick), .rxd(rxd), .txd(txd),
    .txIrq(txIrq), .rxIrq(rxIrq)
  );

  int tickDiv = 3;
  int tickCnt = 0;
  int bitClks = 48;
  int total = 0;
  int bad = 0;
  bit finished = 0;

  always @(posedge clk) begin
    if (tickCnt >= tickDiv - 1) begin
      tickCnt  <= 0;
      baudTick <= 1'b1;
    end else begin
      tickCnt  <= tickCnt + 1;
      baudTick <= 1'b0;
    end
  end

  typedef struct { bit nine; bit [8:0] val; } txItem_t;
  txItem_t expQ[$];

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic regWr(logic a, logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; regAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic regRd(logic a, output logic [7:0] v);
    @(negedge clk);
    regAddr = a;
    #1 v = rdData;
  endtask

  task automatic sendTx(logic [7:0] d, bit nine, bit ninth);
    txItem_t it;
    it.nine = nine;
    it.val  = {ninth, d};
    expQ.push_back(it);
    regWr(1'b1, d);
  endtask

  task automatic waitTx();
    for (int i = 0; i < 4000 && txIrq !== 1'b1; i++) @(negedge clk);
  endtask

  task automatic driveRx(logic [7:0] d, bit nine, bit ninth, bit stopBit);
    @(negedge clk);
    rxd = 1'b0;
    repeat (bitClks) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rxd = d[i];
      repeat (bitClks) @(negedge clk);
    end
    if (nine) begin
      rxd = ninth;
      repeat (bitClks) @(negedge clk);
    end
    rxd = stopBit;
    repeat (bitClks) @(negedge clk);
    rxd = 1'b1;
    repeat (bitClks) @(negedge clk);
  endtask

  // scoreboard monitor on txd (R3)
  initial begin
    txItem_t it;
    logic [8:0] got;
    logic stopV;
    logic startV;
    forever begin
      @(negedge clk);
      if (txd === 1'b0) begin
        repeat (bitClks / 2) @(negedge clk);
        startV = txd;
        got = '0;
        if (expQ.size() == 0) begin
          total++; bad++;
          $display("FAIL R4: unexpected frame actual=1 expected=0");
          it.nine = 0; it.val = '0;
        end else begin
          it = expQ.pop_front();
        end
        for (int i = 0; i < (it.nine ? 9 : 8); i++) begin
          repeat (bitClks) @(negedge clk);
          got[i] = txd;
        end
        repeat (bitClks) @(negedge clk);
        stopV = txd;
        check("R3 start bit", startV, 1'b0);
        check("R3 frame bits", got, it.nine ? it.val : {1'b0, it.val[7:0]});
        check("R3 stop bit", stopV, 1'b1);
        repeat (bitClks / 2) @(negedge clk);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    repeat (4) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    regRd(1'b0, v);
    check("R1 ctrl", v, 8'h00);
    check("R1 txd", txd, 1'b1);
    check("R1 irqs", {txIrq, rxIrq}, 2'b00);

    // 8-bit variable mode
    regWr(1'b0, 8'h53);
    sendTx(8'hA5, 0, 0);
    waitTx();
    check("R4 txIrq set", txIrq, 1'b1);
    regRd(1'b0, v);
    check("R4 ctrl", v, 8'h52);
    regWr(1'b0, 8'h51);
    check("R9 tx clear", txIrq, 1'b0);

    // R4 write while busy ignored
    sendTx(8'h3C, 0, 0);
    regWr(1'b1, 8'hFF);
    waitTx();
    repeat (3 * bitClks) @(negedge clk);
    check("R4 busy write ignored", expQ.size(), 0);
    regWr(1'b0, 8'h51);

    // R6 8-bit receive, stop captured
    driveRx(8'h96, 0, 0, 1);
    check("R6 rxIrq", rxIrq, 1'b1);
    regRd(1'b1, v);
    check("R6 data", v, 8'h96);
    regRd(1'b0, v);
    check("R6 ctrl stop", v, 8'h55);

    // R9 written ones do not set, bit2 read-only, zero clears
    regWr(1'b0, 8'h5E);
    regRd(1'b0, v);
    check("R9 mask write", v, 8'h5C);

    // R8 bad stop
    driveRx(8'h11, 0, 0, 0);
    check("R8 no flag", rxIrq, 1'b0);
    regRd(1'b1, v);
    check("R8 loaded", v, 8'h11);
    regRd(1'b0, v);
    check("R8 ctrl", v, 8'h58);

    // R5 receive disabled
    regWr(1'b0, 8'h43);
    driveRx(8'h22, 0, 0, 1);
    check("R5 no flag", rxIrq, 1'b0);
    regRd(1'b1, v);
    check("R5 buffer kept", v, 8'h11);

    // 9-bit variable mode transmit
    regWr(1'b0, 8'hDB);
    sendTx(8'h5A, 1, 1);
    waitTx();
    regWr(1'b0, 8'hD1);
    sendTx(8'h81, 1, 0);
    waitTx();
    check("R3 9-bit tx done", txIrq, 1'b1);
    regWr(1'b0, 8'hD1);

    // R6 9-bit receive
    driveRx(8'h3E, 1, 0, 1);
    check("R6 9-bit flag", rxIrq, 1'b1);
    regRd(1'b1, v);
    check("R6 9-bit data", v, 8'h3E);
    regRd(1'b0, v);
    check("R6 9-bit ctrl", v, 8'hD1);

    // R7 multiprocessor filter
    regWr(1'b0, 8'hF2);
    driveRx(8'h44, 1, 0, 1);
    check("R7 data frame no flag", rxIrq, 1'b0);
    regRd(1'b1, v);
    check("R7 data frame not loaded", v, 8'h3E);
    driveRx(8'h07, 1, 1, 1);
    check("R7 address flag", rxIrq, 1'b1);
    regRd(1'b1, v);
    check("R7 address data", v, 8'h07);
    regRd(1'b0, v);
    check("R7 ctrl", v, 8'hF5);

    // R2 fixed-rate 9-bit mode
    regWr(1'b0, 8'h92);
    bitClks = 64;
    sendTx(8'hC3, 1, 0);
    waitTx();
    check("R2 fixed tx done", txIrq, 1'b1);
    regWr(1'b0, 8'h91);

    // R10 glitch rejection
    @(negedge clk);
    rxd = 1'b0;
    repeat (8) @(negedge clk);
    rxd = 1'b1;
    repeat (64) @(negedge clk);
    driveRx(8'h5B, 1, 1, 1);
    check("R10 flag", rxIrq, 1'b1);
    regRd(1'b1, v);
    check("R10 data", v, 8'h5B);
    regRd(1'b0, v);
    check("R10 ctrl", v, 8'h95);

    // R2 mode off
    regWr(1'b0, 8'h10);
    regWr(1'b1, 8'h99);
    repeat (12 * 64) @(negedge clk);
    check("R2 off no tx flag", txIrq, 1'b0);
    check("R2 off txd idle", txd, 1'b1);
    driveRx(8'h66, 1, 1, 1);
    check("R2 off no rx flag", rxIrq, 1'b0);
    regRd(1'b1, v);
    check("R2 off buffer kept", v, 8'h5B);

    check("R3 queue drained", expQ.size(), 0);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule